// File: doc/BRIEF.md
# Byte-Wide Configuration Memory Walker

This block fetches a configuration image out of an external byte-wide memory and turns it into a serial bit stream. It drives the memory address, waits a fixed number of cycles for the memory to answer, and captures the byte on its eight data inputs. It then sends that byte out one bit per configuration-clock strobe, most significant bit first. Every fetched address yields exactly eight strobes, so the configuration clock runs at eight times the address rate.

Two walking directions exist. The upward walk starts at the lowest address and counts up. The downward walk starts at the highest address and counts down. This lets the image sit at either end of a memory that a processor shares. While the walk runs, an active-low memory enable is held low and an active-high busy flag is held high. The walk ends when the downstream loader raises its done input. Any address-range overflow simply wraps.

Top module: `cfgmem_walker`

## Requirements
- R1: During and straight after reset, busy is 0, the memory enable is 1, the strobe and serial bit are 0, and the address is all zeros.
- R2: A start pulse taken while idle with high_mode_i = 0 loads address 0. After the eighth bit of each byte, the address increases by one.
- R3: A start pulse taken while idle with high_mode_i = 1 loads the all-ones address. After the eighth bit of each byte, the address decreases by one.
- R4: The address wraps modulo 2^AW in both directions (all ones to zero going up, zero to all ones going down), and the walk carries on without interruption.
- R5: A new address is held for RD_LAT cycles before its byte is captured. Only then are the strobes of that byte issued, while the address is still held. Each byte therefore occupies RD_LAT + 8 cycles, and the first strobe comes in cycle RD_LAT + 1 after the start edge.
- R6: Each byte produces eight strobes on consecutive cycles. cfg_bit_o carries data bit 7 with the first strobe and bit 0 with the eighth. cfg_bit_o is 0 whenever the strobe is 0.
- R7: mem_en_n_o is the exact complement of busy_o. busy_o is 1 from the cycle after an accepted start until the walk ends. A strobe only occurs while busy.
- R8: done_i seen at a clock edge while busy ends the walk: from the next cycle, busy is 0 and strobes stop. While idle, the address holds. A start that arrives together with done_i is ignored.
- R9: A start pulse while busy has no effect on the address sequence or the bit stream.
- R10: The walk direction is taken from high_mode_i only when a start is accepted. Changing high_mode_i during a walk has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (taken only while idle) |
| high_mode_i | input | 1 | 1: walk down from the top address; 0: walk up from zero |
| done_i | input | 1 | Downstream loader finished; ends the walk |
| mem_data_i | input | 8 | Byte returned by the memory |
| mem_addr_o | output | AW | Memory address |
| mem_en_n_o | output | 1 | Active-low memory enable, low while walking |
| busy_o | output | 1 | High while walking |
| cclk_stb_o | output | 1 | Configuration-clock strobe, one per serial bit |
| cfg_bit_o | output | 1 | Serial configuration bit, valid with the strobe |

## Verification
After a start edge, every output is a pure function of the number of cycles k counted from that edge. The address for byte n = (k-1) div (RD_LAT+8) is in place from cycle 1 of that byte's window. The strobe is high when (k-1) mod (RD_LAT+8) is at least RD_LAT. The serial bit in a strobe cycle is the byte's bit 7 minus the strobe's index within the byte. The bench samples at the falling edge of every cycle and compares all outputs against these formulas. The memory model returns a wrong byte until the address has been stable for RD_LAT-1 sampling points, so a capture one cycle early shows up as a corrupted bit stream. After done_i, the idle outputs are checked from the first falling edge following the clock edge that took done_i.

// File: rtl/pwalk_pkg.sv
package pwalk_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_WAIT  = 2'd1,
        WALK_SHIFT = 2'd2
    } walk_state_e;

    // Per-cycle commands from the sequencer to the datapath
    typedef struct packed {
        logic load_base;
        logic step;
        logic capture;
        logic shift;
    } walk_ctl_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pwalk_seq.sv
module pwalk_seq
    import pwalk_pkg::*;
#(
    parameter int unsigned RD_LAT = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      done_i,
    output walk_ctl_t ctl_o,
    output logic      busy_o,
    output logic      strobe_o
);

    localparam int unsigned LAT_W = cnt_w(RD_LAT + 1);
    localparam int unsigned BIT_W = cnt_w(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    walk_state_e      state_q, state_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic             lat_last;

    generate
        if (RD_LAT <= 1) begin : g_no_lat
            assign lat_last = 1'b1;
        end else begin : g_lat
            logic [LAT_W-1:0] lat_q;
            always_ff @(posedge clk) begin
                if (rst || state_q != WALK_WAIT) begin
                    lat_q <= '0;
                end else begin
                    lat_q <= lat_q + 1'b1;
                end
            end
            assign lat_last = (lat_q == LAT_W'(RD_LAT - 1));
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        ctl_o   = '0;
        case (state_q)
            WALK_IDLE: begin
                if (start_i && !done_i) begin
                    ctl_o.load_base = 1'b1;
                    state_d         = WALK_WAIT;
                end
            end
            WALK_WAIT: begin
                if (done_i) begin
                    state_d = WALK_IDLE;
                end else if (lat_last) begin
                    ctl_o.capture = 1'b1;
                    bit_d         = '0;
                    state_d       = WALK_SHIFT;
                end
            end
            WALK_SHIFT: begin
                ctl_o.shift = 1'b1;
                if (done_i) begin
                    state_d = WALK_IDLE;
                end else if (bit_q == LAST_BIT) begin
                    ctl_o.step = 1'b1;
                    state_d    = WALK_WAIT;
                end else begin
                    bit_d = bit_q + 1'b1;
                end
            end
            default: state_d = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    assign busy_o   = (state_q != WALK_IDLE);
    assign strobe_o = (state_q == WALK_SHIFT);

endmodule

// File: rtl/pwalk_addr.sv
module pwalk_addr #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          high_mode_i,
    input  logic          load_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o
);

    logic [AW-1:0] addr_q;
    logic          down_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            down_q <= 1'b0;
        end else if (load_i) begin
            addr_q <= high_mode_i ? '1 : '0;
            down_q <= high_mode_i;
        end else if (step_i) begin
            addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/pwalk_ser.sv
module pwalk_ser
    import pwalk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              msb_o
);

    logic [BYTE_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (capture_i) begin
            sh_q <= data_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign msb_o = sh_q[BYTE_W-1];

endmodule

// File: rtl/cfgmem_walker.sv
module cfgmem_walker
    import pwalk_pkg::*;
#(
    parameter int unsigned AW     = 16,
    parameter int unsigned RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              high_mode_i,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] mem_data_i,
    output logic [AW-1:0]     mem_addr_o,
    output logic              mem_en_n_o,
    output logic              busy_o,
    output logic              cclk_stb_o,
    output logic              cfg_bit_o
);

    walk_ctl_t ctl;
    logic      busy;
    logic      strobe;
    logic      msb;

    pwalk_seq #(.RD_LAT(RD_LAT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .done_i   (done_i),
        .ctl_o    (ctl),
        .busy_o   (busy),
        .strobe_o (strobe)
    );

    pwalk_addr #(.AW(AW)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .high_mode_i (high_mode_i),
        .load_i      (ctl.load_base),
        .step_i      (ctl.step),
        .addr_o      (mem_addr_o)
    );

    pwalk_ser u_ser (
        .clk       (clk),
        .rst       (rst),
        .capture_i (ctl.capture),
        .shift_i   (ctl.shift),
        .data_i    (mem_data_i),
        .msb_o     (msb)
    );

    assign busy_o     = busy;
    assign mem_en_n_o = ~busy;
    assign cclk_stb_o = strobe;
    assign cfg_bit_o  = strobe & msb;

endmodule

// File: rtl/cfgmem_walker_chk.sv
module cfgmem_walker_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          done_i,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_en_n_o,
    input logic          busy_o,
    input logic          cclk_stb_o,
    input logic          cfg_bit_o
);

    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else begin
            run_q <= cclk_stb_o ? run_q + 1'b1 : 4'd0;
        end
    end

    p_en_compl_r7: assert property (@(posedge clk) disable iff (rst)
        mem_en_n_o != busy_o);

    p_stb_busy_r7: assert property (@(posedge clk) disable iff (rst)
        cclk_stb_o |-> busy_o);

    p_done_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (done_i && busy_o) |=> (!busy_o && !cclk_stb_o));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o)) |-> $stable(mem_addr_o));

    p_base_addr_r2_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (mem_addr_o == '0 || mem_addr_o == '1));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && !$stable(mem_addr_o)) |->
        (mem_addr_o == $past(mem_addr_o) + 1'b1 ||
         mem_addr_o == $past(mem_addr_o) - 1'b1));

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cclk_stb_o && $past(cclk_stb_o)) |-> $stable(mem_addr_o));

    p_bit_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !cclk_stb_o |-> !cfg_bit_o);

    p_run_len_r6: assert property (@(posedge clk) disable iff (rst)
        cclk_stb_o |-> (run_q < 4'd8));

endmodule

bind cfgmem_walker cfgmem_walker_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .done_i     (done_i),
    .mem_addr_o (mem_addr_o),
    .mem_en_n_o (mem_en_n_o),
    .busy_o     (busy_o),
    .cclk_stb_o (cclk_stb_o),
    .cfg_bit_o  (cfg_bit_o)
);

// File: tb/test_cfgmem_walker.sv
module test_cfgmem_walker;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int RD_LAT     = 2;
    localparam int PER        = RD_LAT + 8;
    localparam int AMASK      = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          high_mode_i = 1'b0;
    logic          done_i = 1'b0;
    logic [7:0]    mem_data_i = 8'h00;
    logic [AW-1:0] mem_addr_o;
    logic          mem_en_n_o;
    logic          busy_o;
    logic          cclk_stb_o;
    logic          cfg_bit_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    cfgmem_walker #(.AW(AW), .RD_LAT(RD_LAT)) i_cfgmem_walker (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .high_mode_i (high_mode_i),
        .done_i      (done_i),
        .mem_data_i  (mem_data_i),
        .mem_addr_o  (mem_addr_o),
        .mem_en_n_o  (mem_en_n_o),
        .busy_o      (busy_o),
        .cclk_stb_o  (cclk_stb_o),
        .cfg_bit_o   (cfg_bit_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 91) ^ (a >> 2));
    endfunction

    // Memory model: correct byte only once the address has been held long enough
    logic [AW-1:0] prev_addr = '0;
    int            stab = 100;
    always @(negedge clk) begin
        if (mem_addr_o == prev_addr) begin
            if (stab < 100) stab = stab + 1;
        end else begin
            stab = 0;
        end
        prev_addr = mem_addr_o;
        mem_data_i = (stab >= RD_LAT - 1) ? pat(int'(mem_addr_o)) : ~pat(int'(mem_addr_o));
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req, input int exp_addr);
        chk(req, "busy", int'(busy_o), 0);
        chk(req, "enable_n", int'(mem_en_n_o), 1);
        chk(req, "strobe", int'(cclk_stb_o), 0);
        chk(req, "bit", int'(cfg_bit_o), 0);
        chk(req, "addr", int'(mem_addr_o), exp_addr);
    endtask

    // Start a walk, then check every cycle k = 1..ncyc; done_i is applied in cycle ncyc
    task automatic run_walk(input bit hi, input int ncyc, input int restart_at, input int flip_at);
        int last_addr;
        last_addr = 0;
        high_mode_i = hi;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= ncyc; k++) begin
            int n, ph, ea, bi;
            string rq;
            n  = (k - 1) / PER;
            ph = (k - 1) % PER;
            ea = hi ? ((AMASK - n) & AMASK) : (n & AMASK);
            rq = hi ? "R3" : "R2";
            if (n > AMASK) rq = "R4";
            chk(rq, "addr", int'(mem_addr_o), ea);
            chk("R7", "busy", int'(busy_o), 1);
            chk("R7", "enable_n", int'(mem_en_n_o), 0);
            chk("R5", "strobe", int'(cclk_stb_o), (ph >= RD_LAT) ? 1 : 0);
            if (ph >= RD_LAT) begin
                bi = 7 - (ph - RD_LAT);
                chk("R6", "bit", int'(cfg_bit_o), int'(pat(ea) >> bi) & 1);
            end else begin
                chk("R6", "quiet bit", int'(cfg_bit_o), 0);
            end
            last_addr = ea;
            start_i = (k == restart_at);           // R9: ignored while busy
            if (k == flip_at) high_mode_i = ~hi;   // R10: ignored while busy
            done_i = (k == ncyc);
            @(negedge clk);
        end
        done_i = 1'b0;
        start_i = 1'b0;
        for (int j = 0; j < 4; j++) begin
            check_idle("R8", last_addr);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1", 0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1", 0);

        // Upward walk past the wrap, with a stray start and a mode flip
        run_walk(1'b0, 205, 37, 58);
        // Downward walk past the wrap, ended in the middle of a byte
        run_walk(1'b1, 167, 12, 90);
        // Short upward walk ended during the latency wait
        run_walk(1'b0, 1, 0, 0);

        // R8: start together with done is ignored
        high_mode_i = 1'b1;
        start_i = 1'b1;
        done_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        done_i = 1'b0;
        check_idle("R8", 0);
        @(negedge clk);
        check_idle("R8", 0);

        // Downward walk from a fresh start with a latency-long stint only
        run_walk(1'b1, PER + 3, 0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule